// File: doc/BRIEF.md
# Destructive-Readout Pulse Logic Cell

This block is a clocked, event-level model of a single-loop superconducting logic cell that holds one state bit until it is read. Input, preset and read events arrive as one-cycle strobes on a fast system clock. The bit lives in one of two branches: state 0 means current flows in the left branch, and state 1 means it flows in the right branch. An event changes the state only when it switches the branch that is carrying current. A read of a stored 1 sends out a one-cycle output strobe and clears the cell. A read of a 0 does nothing. The cell therefore computes only when it is read, and reading destroys the result.

The parameter `KIND` picks the cell variant:
- `CELL_MEM` is a plain memory with one input.
- `CELL_OR` is an OR of up to four inputs.
- `CELL_NOT` is an inverter with one input.
- `CELL_NOR` is a NOR of up to four inputs.

The two inverting variants are first preset to 1. Any input strobe then clears them, and a later read delivers the inverted result.

Each branch needs a recovery time after it switches. That time is derived from a setup time and the clock period. If one branch switches while the other branch is still recovering, the cell enters a latched fault. In the fault it gives no output and ignores every strobe. Only dropping `bias_en` clears the fault.

Top module: `pulse_logic_cell`

## Requirements
- R1: While `bias_en` is low, and at the first cycle after reset, `state_o`, `lockup_o` and `out_stb` are 0. After bias is applied, the cell starts in state 0.
- R2: In `CELL_MEM` or `CELL_OR` mode, an input strobe in state 0 sets `state_o` to 1 on the next cycle. In `CELL_OR` mode a strobe on any single bit of `in_stb` is enough. In `CELL_MEM` mode only `in_stb[0]` exists.
- R3: A read strobe in state 1 raises `out_stb` for exactly the next cycle and returns `state_o` to 0 on that same cycle.
- R4: A read strobe in state 0 gives no output strobe and leaves the state at 0.
- R5: In `CELL_NOT` or `CELL_NOR` mode, `preset_stb` in state 0 sets the state to 1. A strobe on any input bit in state 1 clears the state to 0.
- R6: `out_stb` is raised only in the cycle after a read strobe. Input strobes, including those in the inverting modes, never produce an output.
- R7: In `CELL_MEM` and `CELL_OR` modes, `preset_stb` has no effect on state or output.
- R8: A switch sets a per-branch recovery window of `RECOV_CYC` cycles. An opposite-branch switch that is strobed fewer than `RECOV_CYC` cycles after the earlier switch is a conflict. The conflict sets `lockup_o` on the next cycle, gives no output, and keeps the state it had before that cycle. A switch exactly `RECOV_CYC` cycles later is legal.
- R9: Strobes in the same cycle are resolved in this order: preset, then inputs, then read. If that sequence switches both branches within the same cycle, it is a conflict, as described in R8.
- R10: While locked, the cell gives no output, ignores all strobes and holds `state_o`. It stays locked until `bias_en` goes low. When bias is applied again, the cell is back in state 0 and no longer locked.
- R11: `RECOV_CYC` is the setup time divided by the clock period, rounded up. The defaults (10000 ps, 4000 ps) give 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bias_en | input | 1 | Loop bias. Low clears the state, the fault and the recovery timers |
| in_stb | input | N_IN | Input event strobes, one bit per input |
| preset_stb | input | 1 | Preset event strobe. Used only by the inverting variants |
| read_stb | input | 1 | Read event strobe |
| out_stb | output | 1 | One-cycle output strobe when a stored 1 is read |
| state_o | output | 1 | Current state bit, for observation |
| lockup_o | output | 1 | Latched recovery-conflict fault |

## Verification
Several events can fall in the same cycle and interact:
- A read can coincide with the input or preset that loads the bit.
- A preset can coincide with an input in the inverting modes.
- A read can land one cycle short of, or exactly at, the end of the opposite branch's recovery window.

The bench provokes each case by driving the strobes together, or at a chosen gap, to four instances at once: one of each variant. A behavioural model tracks the cycle of the last switch of each branch and applies the preset/input/read order. Every cycle, the model judges whether each instance should update, emit an output or lock, and compares state, output and fault against it.

// File: rtl/plc_pkg.sv
package plc_pkg;

   typedef enum logic [1:0] {
      CELL_MEM = 2'd0,
      CELL_OR  = 2'd1,
      CELL_NOT = 2'd2,
      CELL_NOR = 2'd3
   } cell_kind_e;

   // Outcome of one cycle's events, in preset/input/read order
   typedef struct packed {
      logic sw_left;
      logic sw_right;
      logic fire;
      logic conflict;
      logic next_state;
   } resolve_t;

   function automatic logic kind_inverting(cell_kind_e k);
      return (k == CELL_NOT) || (k == CELL_NOR);
   endfunction

   function automatic logic kind_multi_input(cell_kind_e k);
      return (k == CELL_OR) || (k == CELL_NOR);
   endfunction

endpackage

// File: rtl/plc_input_merge.sv
module plc_input_merge #(
   parameter int unsigned N_IN = 1
) (
   input  logic [N_IN-1:0] in_stb,
   output logic            any_stb
);
   generate
      if (N_IN == 1) begin : g_single
         assign any_stb = in_stb[0];
      end else begin : g_multi
         logic [N_IN-1:0] chain;
         assign chain[0] = in_stb[0];
         for (genvar i = 1; i < N_IN; i++) begin : g_or
            assign chain[i] = chain[i-1] | in_stb[i];
         end
         assign any_stb = chain[N_IN-1];
      end
   endgenerate
endmodule

// File: rtl/plc_recovery_timer.sv
module plc_recovery_timer #(
   parameter int unsigned HOLD_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic start,
   output logic busy
);
   localparam int unsigned CW = $clog2(HOLD_CYC + 1);
   localparam logic [CW-1:0] LOAD_VAL = CW'(HOLD_CYC - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (start) begin
         cnt_q <= LOAD_VAL;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy = (cnt_q != '0);
endmodule

// File: rtl/plc_event_resolve.sv
module plc_event_resolve
   import plc_pkg::*;
#(
   parameter cell_kind_e KIND = CELL_NOR
) (
   input  logic     state_q,
   input  logic     any_in,
   input  logic     preset,
   input  logic     read,
   input  logic     busy_left,
   input  logic     busy_right,
   output resolve_t res
);
   generate
      if (kind_inverting(KIND)) begin : g_inv
         // preset lives in the left branch, inputs and read in the right
         always_comb begin
            logic s;
            res = '0;
            s   = state_q;
            if (preset && !s) begin
               if (busy_right) res.conflict = 1'b1;
               res.sw_left = 1'b1;
               s = 1'b1;
            end
            if (any_in && s) begin
               if (busy_left || res.sw_left) res.conflict = 1'b1;
               res.sw_right = 1'b1;
               s = 1'b0;
            end
            if (read && s) begin
               if (busy_left || res.sw_left) res.conflict = 1'b1;
               res.sw_right = 1'b1;
               res.fire     = 1'b1;
               s = 1'b0;
            end
            res.next_state = s;
         end
      end else begin : g_noninv
         // inputs in the left branch, read in the right; preset absent
         always_comb begin
            logic s;
            res = '0;
            s   = state_q;
            if (any_in && !s) begin
               if (busy_right) res.conflict = 1'b1;
               res.sw_left = 1'b1;
               s = 1'b1;
            end
            if (read && s) begin
               if (busy_left || res.sw_left) res.conflict = 1'b1;
               res.sw_right = 1'b1;
               res.fire     = 1'b1;
               s = 1'b0;
            end
            res.next_state = s;
         end
      end
   endgenerate

   logic unused_preset;
   assign unused_preset = preset;
endmodule

// File: rtl/pulse_logic_cell.sv
module pulse_logic_cell
   import plc_pkg::*;
#(
   parameter cell_kind_e  KIND         = CELL_NOR,
   parameter int unsigned N_IN         = 2,
   parameter int unsigned CLK_PERIOD_PS = 4000,
   parameter int unsigned SETUP_PS     = 10000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bias_en,
   input  logic [N_IN-1:0] in_stb,
   input  logic            preset_stb,
   input  logic            read_stb,
   output logic            out_stb,
   output logic            state_o,
   output logic            lockup_o
);
   localparam int unsigned RECOV_CYC_RAW = (SETUP_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
   localparam int unsigned RECOV_CYC     = (RECOV_CYC_RAW < 1) ? 1 : RECOV_CYC_RAW;

   generate
      if (N_IN < 1 || N_IN > 4) begin : g_bad_nin
         $error("pulse_logic_cell: N_IN must lie in 1..4");
      end
      if (!kind_multi_input(KIND) && N_IN != 1) begin : g_bad_single
         $error("pulse_logic_cell: single-input kinds require N_IN == 1");
      end
      if (CLK_PERIOD_PS == 0) begin : g_bad_clk
         $error("pulse_logic_cell: CLK_PERIOD_PS must be nonzero");
      end
   endgenerate

   logic     any_in;
   logic     busy_left, busy_right;
   logic     state_q, lock_q, out_q;
   logic     live;
   resolve_t res;

   plc_input_merge #(.N_IN(N_IN)) u_merge (
      .in_stb  (in_stb),
      .any_stb (any_in)
   );

   plc_event_resolve #(.KIND(KIND)) u_resolve (
      .state_q    (state_q),
      .any_in     (any_in),
      .preset     (preset_stb),
      .read       (read_stb),
      .busy_left  (busy_left),
      .busy_right (busy_right),
      .res        (res)
   );

   assign live = bias_en && !lock_q && !res.conflict;

   plc_recovery_timer #(.HOLD_CYC(RECOV_CYC)) u_tmr_left (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (!bias_en),
      .start (live && res.sw_left),
      .busy  (busy_left)
   );

   plc_recovery_timer #(.HOLD_CYC(RECOV_CYC)) u_tmr_right (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (!bias_en),
      .start (live && res.sw_right),
      .busy  (busy_right)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= 1'b0;
         lock_q  <= 1'b0;
         out_q   <= 1'b0;
      end else if (!bias_en) begin
         state_q <= 1'b0;
         lock_q  <= 1'b0;
         out_q   <= 1'b0;
      end else if (lock_q) begin
         out_q   <= 1'b0;
      end else if (res.conflict) begin
         lock_q  <= 1'b1;
         out_q   <= 1'b0;
      end else begin
         state_q <= res.next_state;
         out_q   <= res.fire;
      end
   end

   assign out_stb  = out_q;
   assign state_o  = state_q;
   assign lockup_o = lock_q;
endmodule

// File: rtl/pulse_logic_cell_chk.sv
module pulse_logic_cell_chk #(
   parameter int unsigned N_IN = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            bias_en,
   input logic [N_IN-1:0] in_stb,
   input logic            preset_stb,
   input logic            read_stb,
   input logic            out_stb,
   input logic            state_o,
   input logic            lockup_o
);
   assert_bias_off_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !bias_en |=> (!state_o && !lockup_o && !out_stb));

   assert_out_only_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_stb |-> ($past(read_stb) && $past(state_o) && $past(bias_en) && !$past(lockup_o)));

   assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_stb |-> !state_o);

   assert_read_zero_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bias_en && read_stb && !state_o && !lockup_o && !preset_stb && (in_stb == '0))
      |=> (!out_stb && !state_o));

   assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (lockup_o && bias_en) |=> (lockup_o && $stable(state_o)));

   assert_lock_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
      lockup_o |-> !out_stb);
endmodule

bind pulse_logic_cell pulse_logic_cell_chk #(.N_IN(N_IN)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bias_en    (bias_en),
   .in_stb     (in_stb),
   .preset_stb (preset_stb),
   .read_stb   (read_stb),
   .out_stb    (out_stb),
   .state_o    (state_o),
   .lockup_o   (lockup_o)
);

// File: tb/pulse_logic_cell_tb.sv
module pulse_logic_cell_tb;
   import plc_pkg::*;

   localparam int RECOV = 3;   // 10000 ps / 4000 ps rounded up (R11)

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bias = 1'b0;
   logic [2:0] ins = '0;
   logic       pre = 1'b0;
   logic       rd = 1'b0;

   logic [3:0] o_out, o_st, o_lk;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // model state per instance: 0 mem, 1 or, 2 not, 3 nor
   bit m_st [4];
   bit m_lk [4];
   bit m_out[4];
   int last_l[4];
   int last_r[4];
   int cyc = 0;

   always #2 clk = ~clk;   // 250 MHz

   pulse_logic_cell #(.KIND(CELL_MEM), .N_IN(1)) u_mem (
      .clk(clk), .rst_n(rst_n), .bias_en(bias), .in_stb(ins[0:0]),
      .preset_stb(pre), .read_stb(rd),
      .out_stb(o_out[0]), .state_o(o_st[0]), .lockup_o(o_lk[0]));

   pulse_logic_cell #(.KIND(CELL_OR), .N_IN(3)) u_or (
      .clk(clk), .rst_n(rst_n), .bias_en(bias), .in_stb(ins),
      .preset_stb(pre), .read_stb(rd),
      .out_stb(o_out[1]), .state_o(o_st[1]), .lockup_o(o_lk[1]));

   pulse_logic_cell #(.KIND(CELL_NOT), .N_IN(1)) u_not (
      .clk(clk), .rst_n(rst_n), .bias_en(bias), .in_stb(ins[0:0]),
      .preset_stb(pre), .read_stb(rd),
      .out_stb(o_out[2]), .state_o(o_st[2]), .lockup_o(o_lk[2]));

   pulse_logic_cell #(.KIND(CELL_NOR), .N_IN(3)) u_dut (
      .clk(clk), .rst_n(rst_n), .bias_en(bias), .in_stb(ins),
      .preset_stb(pre), .read_stb(rd),
      .out_stb(o_out[3]), .state_o(o_st[3]), .lockup_o(o_lk[3]));

   task automatic model_clear();
      for (int k = 0; k < 4; k++) begin
         m_st[k] = 0; m_lk[k] = 0; m_out[k] = 0;
         last_l[k] = -1000; last_r[k] = -1000;
      end
   endtask

   task automatic model_cycle();
      for (int k = 0; k < 4; k++) begin
         bit inv, any, s, swl, swr, conf, fire;
         inv  = (k >= 2);
         any  = (k == 0 || k == 2) ? ins[0] : (ins != 0);
         s    = m_st[k];
         swl  = 0; swr = 0; conf = 0; fire = 0;
         if (!bias) begin
            m_st[k] = 0; m_lk[k] = 0; m_out[k] = 0;
            last_l[k] = -1000; last_r[k] = -1000;
         end else if (m_lk[k]) begin
            m_out[k] = 0;
         end else begin
            if (inv && pre && !s) begin
               if (cyc - last_r[k] < RECOV) conf = 1;
               swl = 1; s = 1;
            end
            if (any) begin
               if (!inv && !s) begin
                  if (cyc - last_r[k] < RECOV) conf = 1;
                  swl = 1; s = 1;
               end else if (inv && s) begin
                  if (cyc - last_l[k] < RECOV || swl) conf = 1;
                  swr = 1; s = 0;
               end
            end
            if (rd && s) begin
               if (cyc - last_l[k] < RECOV || swl) conf = 1;
               swr = 1; fire = 1; s = 0;
            end
            if (conf) begin
               m_lk[k] = 1; m_out[k] = 0;
            end else begin
               m_st[k] = s; m_out[k] = fire;
               if (swl) last_l[k] = cyc;
               if (swr) last_r[k] = cyc;
            end
         end
      end
      cyc++;
   endtask

   task automatic compare(string tag);
      for (int k = 0; k < 4; k++) begin
         checks++;
         if (o_out[k] !== m_out[k] || o_st[k] !== m_st[k] || o_lk[k] !== m_lk[k]) begin
            fails++;
            $display("FAIL %s cell%0d cyc %0d: out/state/lock actual %b%b%b expected %b%b%b",
                     tag, k, cyc, o_out[k], o_st[k], o_lk[k], m_out[k], m_st[k], m_lk[k]);
         end
      end
   endtask

   // called at a falling edge: drive, predict, advance one cycle, compare
   task automatic step(string tag, bit b, logic [2:0] i, bit p, bit r);
      bias = b; ins = i; pre = p; rd = r;
      model_cycle();
      @(negedge clk);
      compare(tag);
   endtask

   task automatic idle(string tag, int n);
      for (int j = 0; j < n; j++) step(tag, 1, 3'b000, 0, 0);
   endtask

   task automatic rebias(string tag);
      step(tag, 0, 3'b000, 0, 0);
      idle(tag, 4);
   endtask

   task automatic summary();
      $display("  %0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      model_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      compare("R1 reset");
      step("R1 bias off", 0, 3'b000, 0, 0);
      idle("R1 bias on", 4);

      // R2/R3/R4 memory and OR
      step("R2 input0", 1, 3'b001, 0, 0);   idle("R2", 4);
      step("R3 read one", 1, 3'b000, 0, 1); idle("R3", 4);
      step("R4 read zero", 1, 3'b000, 0, 1); idle("R4", 4);
      step("R2 input2 or-only", 1, 3'b100, 0, 0); idle("R2", 4);
      step("R3 read", 1, 3'b000, 0, 1);     idle("R3", 4);

      // R5/R6/R7 inverting cells, preset ignored by others
      step("R5 R7 preset", 1, 3'b000, 1, 0); idle("R7", 4);
      step("R5 read preset", 1, 3'b000, 0, 1); idle("R5", 4);
      step("R5 preset", 1, 3'b000, 1, 0);    idle("R5", 4);
      step("R6 input1 clears nor", 1, 3'b010, 0, 0); idle("R6", 4);
      step("R5 read", 1, 3'b000, 0, 1);      idle("R5", 4);
      step("R5 preset", 1, 3'b000, 1, 0);    idle("R5", 4);
      step("R6 input0 clears both", 1, 3'b001, 0, 0); idle("R6", 4);
      step("R4 read inverted zero", 1, 3'b000, 0, 1); idle("R4", 4);

      // R8/R11 window boundary: exactly RECOV cycles is legal
      step("R11 input", 1, 3'b001, 0, 0);   idle("R11", RECOV - 1);
      step("R11 read at window", 1, 3'b000, 0, 1); idle("R8", 4);
      // one cycle short: lockup
      step("R8 input", 1, 3'b001, 0, 0);    idle("R8", RECOV - 2);
      step("R8 early read", 1, 3'b000, 0, 1); idle("R8", 2);
      // R10 strobes ignored while locked
      step("R10 input locked", 1, 3'b001, 0, 0);
      step("R10 preset locked", 1, 3'b000, 1, 0);
      step("R10 read locked", 1, 3'b000, 0, 1);
      idle("R10", 4);
      rebias("R10 bias cycle");

      // R8 read then immediate new write
      step("R8 set", 1, 3'b001, 0, 0);      idle("R8", 4);
      step("R8 read", 1, 3'b000, 0, 1);
      step("R8 write in right window", 1, 3'b001, 0, 0); idle("R8", 3);
      rebias("R10 bias cycle");

      // R9 same-cycle ordering
      step("R9 preset+read", 1, 3'b000, 1, 1); idle("R9", 3);
      rebias("R9 bias cycle");
      step("R9 preset", 1, 3'b000, 1, 0);    idle("R9", 4);
      step("R9 preset+input+read", 1, 3'b010, 1, 1); idle("R9", 4);
      step("R9 read after", 1, 3'b000, 0, 1); idle("R9", 4);
      step("R9 input+read", 1, 3'b100, 0, 1); idle("R9", 3);
      step("R9 preset+input zero", 1, 3'b001, 1, 0); idle("R9", 3);
      rebias("R1 R10 final bias cycle");
      step("R4 final read", 1, 3'b000, 0, 1); idle("R4", 2);

      done = 1;
      summary();
      $finish;
   end
endmodule